// File: doc/BRIEF.md
# Parallel Acquisition Port Packer

This block takes samples from an external 20-bit parallel bus and builds 32-bit words from them. The samples are taken on one edge of an external acquisition clock. A control bit chooses the rising or the falling edge. A hold input suspends capture: while it is high, a selected edge reads nothing and is not counted as a sample. Work already done on a partial word is kept across the hold.

A two-bit packing mode sets how many samples make one word:
- one full sample, left-justified,
- the upper halves of two samples, or
- the upper bytes of four samples.

Each finished word appears for exactly one cycle on a valid/ready write port that feeds a FIFO. If the FIFO is not ready in that cycle, the word is lost and a sticky overflow flag is raised. The flag stays set until it is cleared through `ovf_clr`.

The acquisition clock is sampled in the system clock domain. Its selected edge becomes a single-cycle capture qualifier, which assumes the acquisition clock is much slower than `clk`. Clearing the enable, or writing a different packing mode, discards a partial word and restarts the sample count.

Top module: `par_acq_packer`

## Requirements
- R1: Mode 0 (`ctrl[1:0]`=0, and also 3) emits one word per captured sample: `{sample[19:0], 12'h000}`.
- R2: Mode 1 (`ctrl[1:0]`=1) places `sample[19:4]` of the first sample in bits 15:0 and of the second in bits 31:16, and emits one word every two samples.
- R3: Mode 2 (`ctrl[1:0]`=2) places `sample[19:12]` of sample k (k=0..3) in bits 8k+7:8k, and emits one word every four samples.
- R4: While `hold` is high, selected edges capture nothing and do not advance the count; a partial word survives the hold.
- R5: `ctrl[29]`=0 captures on the rising edge of `acq_clk`, and `ctrl[29]`=1 captures on the falling edge. The other edge has no effect.
- R6: While `enable` is low nothing is captured, and dropping `enable` discards any partial word.
- R7: A change of `ctrl[1:0]` discards any partial word and restarts the count at zero.
- R8: A word is presented with `wr_valid` high for exactly one cycle, one cycle after the capture that completes it. If `wr_ready` is low in that cycle, `ovf_flag` is set.
- R9: `ovf_flag` stays set until `ovf_clr` is asserted with no new overflow. A new overflow in the same cycle as `ovf_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_clk | input | 1 | External acquisition clock, sampled by `clk` |
| hold | input | 1 | Suspends capture while high |
| din | input | 20 | Parallel sample bus |
| ctrl | input | 32 | Control: bit 29 edge select, bits 1:0 packing mode |
| enable | input | 1 | Capture enable |
| wr_ready | input | 1 | FIFO can accept a word |
| ovf_clr | input | 1 | Clears the overflow flag |
| wr_valid | output | 1 | Word present on `wr_data` |
| wr_data | output | 32 | Packed word |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The overflow flag can be raised by a word the FIFO refuses in the same cycle that `ovf_clr` clears it. The bench provokes this by holding `wr_ready` low and pulsing `ovf_clr` exactly in the cycle `wr_valid` is high. It then expects the flag to stay set. A second collision is a hold or mode change landing mid-word. It is judged by checking that the following word holds only the samples the requirements allow.

// File: rtl/par_acq_packer.sv
module par_acq_packer #(
  parameter int DW       = 20,
  parameter int WW       = 32,
  parameter int EDGE_BIT = 29
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acq_clk,
  input  logic          hold,
  input  logic [DW-1:0] din,
  input  logic [WW-1:0] ctrl,
  input  logic          enable,
  input  logic          wr_ready,
  input  logic          ovf_clr,
  output logic          wr_valid,
  output logic [WW-1:0] wr_data,
  output logic          ovf_flag
);
  localparam int PADW = WW - DW;

  logic          acq_q;
  logic [1:0]    mode_q;
  logic [1:0]    cnt;
  logic [WW-1:0] acc, nxt;

  wire [1:0] mode  = ctrl[1:0];
  wire       rise  = acq_clk & ~acq_q;
  wire       fall  = ~acq_clk & acq_q;
  wire       edge_hit = ctrl[EDGE_BIT] ? fall : rise;
  wire       flush = ~enable | (mode != mode_q);
  wire       take  = edge_hit & ~hold & ~flush;
  wire [15:0] half = din[DW-1 -: 16];
  wire [7:0]  byt  = din[DW-1 -: 8];
  wire       last  = (mode == 2'd1) ? (cnt == 2'd1) :
                     (mode == 2'd2) ? (cnt == 2'd3) : 1'b1;

  always_comb begin
    nxt = acc;
    case (mode)
      2'd1: begin
        if (cnt[0]) nxt[31:16] = half;
        else        nxt[15:0]  = half;
      end
      2'd2: nxt[{cnt, 3'b000} +: 8] = byt;
      default: nxt = {din, {PADW{1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_q    <= 1'b0;
      mode_q   <= 2'd0;
      cnt      <= 2'd0;
      acc      <= '0;
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else begin
      acq_q    <= acq_clk;
      mode_q   <= mode;
      wr_valid <= 1'b0;
      if (flush) begin
        cnt <= 2'd0;
        acc <= '0;
      end else if (take) begin
        if (last) begin
          wr_data  <= nxt;
          wr_valid <= 1'b1;
          cnt      <= 2'd0;
          acc      <= '0;
        end else begin
          acc <= nxt;
          cnt <= cnt + 2'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ovf_flag <= 1'b0;
    else if (wr_valid && !wr_ready) ovf_flag <= 1'b1;
    else if (ovf_clr)               ovf_flag <= 1'b0;
  end
endmodule

module par_acq_packer_chk (
  input logic clk,
  input logic rst_n,
  input logic hold,
  input logic enable,
  input logic wr_valid,
  input logic wr_ready,
  input logic ovf_clr,
  input logic ovf_flag
);
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R8
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ovf_flag);
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);
  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !(wr_valid && !wr_ready)) |=> !ovf_flag);
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !wr_valid);
  // R6
  enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !wr_valid);
endmodule

bind par_acq_packer par_acq_packer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold(hold), .enable(enable),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .ovf_clr(ovf_clr),
  .ovf_flag(ovf_flag)
);

// File: tb/par_acq_packer_test.sv
`timescale 1ns/1ps
module par_acq_packer_test;
  logic        clk = 1'b0, rst_n = 1'b0, acq_clk = 1'b0, hold = 1'b0;
  logic [19:0] din = '0;
  logic [31:0] ctrl = '0;
  logic        enable = 1'b0, wr_ready = 1'b1, ovf_clr = 1'b0;
  logic        wr_valid, ovf_flag;
  logic [31:0] wr_data;

  int total = 0, bad = 0, nwords = 0;
  logic [31:0] lastw = '0;

  always #2 clk = ~clk;

  par_acq_packer uut (
    .clk(clk), .rst_n(rst_n), .acq_clk(acq_clk), .hold(hold), .din(din),
    .ctrl(ctrl), .enable(enable), .wr_ready(wr_ready), .ovf_clr(ovf_clr),
    .wr_valid(wr_valid), .wr_data(wr_data), .ovf_flag(ovf_flag)
  );

  always @(negedge clk) if (wr_valid) begin
    nwords++;
    lastw = wr_data;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(logic [19:0] d, logic h, logic clr);
    @(negedge clk);
    din = d; hold = h; acq_clk = 1'b1;
    @(negedge clk);
    ovf_clr = clr; acq_clk = 1'b0;
    @(negedge clk);
    ovf_clr = 1'b0; hold = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R8 reset valid", {31'd0, wr_valid}, 32'd0);
    check("R9 reset ovf", {31'd0, ovf_flag}, 32'd0);
  endtask

  task automatic t_mode0;
    int n0;
    ctrl = 32'd0; idle(2);
    n0 = nwords;
    pulse(20'hABCDE, 1'b0, 1'b0);
    check("R1 count", nwords - n0, 1);
    check("R1 word", lastw, 32'hABCDE000);
    ctrl = 32'd3; idle(2);
    pulse(20'h54321, 1'b0, 1'b0);
    check("R1 mode3 word", lastw, 32'h54321000);
  endtask

  task automatic t_mode1;
    int n0;
    ctrl = 32'd1; idle(2);
    n0 = nwords;
    pulse(20'h12345, 1'b0, 1'b0);
    check("R2 no early word", nwords - n0, 0);
    pulse(20'h6789A, 1'b0, 1'b0);
    check("R2 word", lastw, 32'h67891234);
    check("R2 count", nwords - n0, 1);
  endtask

  task automatic t_mode2;
    int n0;
    ctrl = 32'd2; idle(2);
    n0 = nwords;
    pulse(20'h11ABC, 1'b0, 1'b0);
    pulse(20'h22DEF, 1'b0, 1'b0);
    pulse(20'h33123, 1'b0, 1'b0);
    check("R3 no early word", nwords - n0, 0);
    pulse(20'h44456, 1'b0, 1'b0);
    check("R3 word", lastw, 32'h44332211);
  endtask

  task automatic t_hold;
    int n0;
    ctrl = 32'd1; idle(2);
    n0 = nwords;
    pulse(20'h12345, 1'b0, 1'b0);
    pulse(20'hFFFFF, 1'b1, 1'b0);
    check("R4 held edge no word", nwords - n0, 0);
    pulse(20'h6789A, 1'b0, 1'b0);
    check("R4 word keeps partial", lastw, 32'h67891234);
  endtask

  task automatic t_fall;
    int n0;
    ctrl = 32'h2000_0000; idle(2);
    n0 = nwords;
    @(negedge clk); din = 20'h13579; acq_clk = 1'b1;
    idle(3);
    check("R5 rising ignored", nwords - n0, 0);
    acq_clk = 1'b0;
    idle(2);
    check("R5 falling count", nwords - n0, 1);
    check("R5 falling word", lastw, 32'h13579000);
    ctrl = 32'd0; idle(2);
  endtask

  task automatic t_enable;
    int n0;
    ctrl = 32'd1; idle(2);
    pulse(20'hAAAAA, 1'b0, 1'b0);
    enable = 1'b0;
    n0 = nwords;
    pulse(20'hFFFFF, 1'b0, 1'b0);
    pulse(20'hFFFFF, 1'b0, 1'b0);
    check("R6 disabled no word", nwords - n0, 0);
    enable = 1'b1; idle(1);
    pulse(20'h12345, 1'b0, 1'b0);
    pulse(20'h6789A, 1'b0, 1'b0);
    check("R6 partial discarded", lastw, 32'h67891234);
  endtask

  task automatic t_modechg;
    ctrl = 32'd1; idle(2);
    pulse(20'hAAAAA, 1'b0, 1'b0);
    ctrl = 32'd2; idle(2);
    pulse(20'h11000, 1'b0, 1'b0);
    pulse(20'h22000, 1'b0, 1'b0);
    pulse(20'h33000, 1'b0, 1'b0);
    pulse(20'h44000, 1'b0, 1'b0);
    check("R7 restart after mode change", lastw, 32'h44332211);
  endtask

  task automatic t_ovf;
    int n0;
    ctrl = 32'd0; idle(2);
    wr_ready = 1'b0;
    n0 = nwords;
    pulse(20'h00001, 1'b0, 1'b0);
    check("R8 single valid cycle", nwords - n0, 1);
    check("R8 ovf set", {31'd0, ovf_flag}, 32'd1);
    wr_ready = 1'b1;
    pulse(20'h00002, 1'b0, 1'b0);
    idle(3);
    check("R9 ovf sticky", {31'd0, ovf_flag}, 32'd1);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    check("R9 ovf cleared", {31'd0, ovf_flag}, 32'd0);
    wr_ready = 1'b0;
    pulse(20'h00003, 1'b0, 1'b1);
    check("R9 set beats clear", {31'd0, ovf_flag}, 32'd1);
    wr_ready = 1'b1;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    enable = 1'b1;
    t_mode0();
    t_mode1();
    t_mode2();
    t_hold();
    t_fall();
    t_enable();
    t_modechg();
    t_ovf();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule